// File: doc/BRIEF.md
# Guarded System Clock Prescaler

This block divides the main clock by a power of two, from 1 up to 256, and emits a one-cycle clock-enable strobe once per system clock period. The division setting sits behind a guard. Software must first store a fixed signature byte into an unlock register. That write opens a short window, measured in retired CPU instructions, and the setting can only be changed while the window is open. While the window is open the block also raises an output that holds off interrupt servicing.

A new setting is never applied in the middle of a period. The divider finishes the period it is currently running at the old length and only then adopts the new length. No period shorter than the shorter of the old and new periods can therefore appear. The divider runs on the main clock, and a separate strobe marks each retired CPU instruction. The CPU clock may be slower than the main clock.

Top module: `guarded_clk_prescaler`

## Requirements
- R1: Writing 0xD8 to the unlock register (`wr_sel` = 0) opens the window in the next cycle. The window stays open until four `instr_done` strobes have been seen in the cycles after that write, and it closes in the cycle after the fourth strobe.
- R2: Writing any value other than 0xD8 to the unlock register does not open the window.
- R3: `unlock_rd` bit 0 is 1 exactly while the window is open, and bits 7:1 always read 0.
- R4: `irq_hold` is high exactly while the window is open.
- R5: After reset the window is closed, `presc_sel` is 3 and the strobe period is 8 main clock cycles.
- R6: A write to the prescale field (`wr_sel` = 1) in a cycle where the window is closed is discarded, and `presc_sel` keeps its value.
- R7: Field code n in the range 0 to 8 gives a strobe period of 2^n main clock cycles. A write of a code from 9 to 15 is ignored.
- R8: A signature write while the window is open restarts the count at four instructions, even if an `instr_done` strobe arrives in the same cycle.
- R9: After an accepted field write, the period already in progress completes at its old length, and every later period uses the new length.
- R10: A field write in the same cycle as the `instr_done` strobe that closes the window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the unlock register, 1 selects the prescale field |
| wr_data | input | 8 | Write data |
| instr_done | input | 1 | One-cycle strobe for each retired CPU instruction |
| unlock_rd | output | 8 | Read value of the unlock register |
| irq_hold | output | 1 | Holds off interrupt servicing while the window is open |
| presc_sel | output | 4 | Prescale field as currently programmed |
| sys_tick | output | 1 | System clock enable, high for one main clock cycle per period |

## Verification
Two coincidences are checked. In the first, a field write lands in the same cycle as the instruction strobe that closes the window; the write must still be taken, and a write one cycle later must be dropped. In the second, a signature write coincides with an instruction strobe; the window must reload to a full four instructions rather than count that strobe. The monitor measures every strobe-to-strobe interval. It compares each one against the period a reference model expects, and that model switches length only on the strobe that follows an accepted write.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
   localparam int GCP_DATA_W = 8;
   localparam int GCP_SEL_W = 4;
   localparam int GCP_MAX_LOG = 8;
   localparam int GCP_RESET_SEL = 3;
   localparam int GCP_WIN_INSTR = 4;
   localparam logic [GCP_DATA_W-1:0] GCP_SIGNATURE = 8'hD8;

   typedef enum logic {
      SEL_UNLOCK = 1'b0,
      SEL_PRESC = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/gcp_unlock_win.sv
module gcp_unlock_win #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] SIG = 8'hD8,
   parameter int WIN_INSTR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_unlock,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              instr_done,
   output logic              win_open,
   output logic [DATA_W-1:0] rd_val
);
   localparam int WIN_W = $clog2(WIN_INSTR + 1);
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_INSTR);

   logic [WIN_W-1:0] left_q;
   logic sig_hit;

   assign sig_hit = wr_unlock && (wr_data == SIG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (sig_hit) begin
         left_q <= WIN_LOAD;
      end else if (instr_done && (left_q != '0)) begin
         left_q <= left_q - WIN_W'(1);
      end
   end

   assign win_open = (left_q != '0);

   generate
      if (DATA_W > 1) begin : g_wide
         assign rd_val = {{(DATA_W-1){1'b0}}, win_open};
      end else begin : g_narrow
         assign rd_val = win_open;
      end
   endgenerate
endmodule

// File: rtl/gcp_field_reg.sv
module gcp_field_reg #(
   parameter int DATA_W = 8,
   parameter int SEL_W = 4,
   parameter int MAX_LOG = 8,
   parameter int RESET_SEL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_presc,
   input  logic              win_open,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEL_W-1:0]  field_q,
   output logic              accept,
   output logic [SEL_W-1:0]  accept_val
);
   localparam logic [DATA_W-1:0] CODE_LIMIT = DATA_W'(MAX_LOG);
   localparam logic [SEL_W-1:0] FIELD_RST = SEL_W'(RESET_SEL);

   assign accept = wr_presc && win_open && (wr_data <= CODE_LIMIT);
   assign accept_val = wr_data[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= FIELD_RST;
      end else if (accept) begin
         field_q <= accept_val;
      end
   end
endmodule

// File: rtl/gcp_divider.sv
module gcp_divider #(
   parameter int SEL_W = 4,
   parameter int MAX_LOG = 8,
   parameter int RESET_SEL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             new_valid,
   input  logic [SEL_W-1:0] new_log,
   output logic             tick
);
   localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;
   localparam logic [SEL_W-1:0] LOG_RST = SEL_W'(RESET_SEL);

   logic [SEL_W-1:0] cur_log_q;
   logic [SEL_W-1:0] pend_log_q;
   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span_w;
   logic [CNT_W:0]   mask_w;
   logic             last;

   assign span_w = (CNT_W+1)'(1) << cur_log_q;
   assign mask_w = span_w - (CNT_W+1)'(1);
   assign last = (cnt_q == mask_w[CNT_W-1:0]);
   assign tick = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_log_q <= LOG_RST;
         pend_log_q <= LOG_RST;
         pend_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (last) begin
            cnt_q <= '0;
            if (pend_q) begin
               cur_log_q <= pend_log_q;
               pend_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (new_valid) begin
            pend_q <= 1'b1;
            pend_log_q <= new_log;
         end
      end
   end
endmodule

// File: rtl/guarded_clk_prescaler.sv
module guarded_clk_prescaler
   import gcp_pkg::*;
#(
   parameter int DATA_W = GCP_DATA_W,
   parameter int SEL_W = GCP_SEL_W,
   parameter int MAX_LOG = GCP_MAX_LOG,
   parameter int RESET_SEL = GCP_RESET_SEL,
   parameter int WIN_INSTR = GCP_WIN_INSTR,
   parameter logic [DATA_W-1:0] SIG = GCP_SIGNATURE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              instr_done,
   output logic [DATA_W-1:0] unlock_rd,
   output logic              irq_hold,
   output logic [SEL_W-1:0]  presc_sel,
   output logic              sys_tick
);
   generate
      if (MAX_LOG >= (1 << SEL_W)) begin : g_bad_sel
         $error("prescale field too narrow for MAX_LOG");
      end
      if (RESET_SEL > MAX_LOG) begin : g_bad_rst
         $error("reset code beyond MAX_LOG");
      end
      if (WIN_INSTR < 1) begin : g_bad_win
         $error("window must span at least one instruction");
      end
      if (DATA_W < SEL_W) begin : g_bad_data
         $error("data bus narrower than prescale field");
      end
   endgenerate

   logic wr_unlock;
   logic wr_presc;
   logic win_open;
   logic accept;
   logic [SEL_W-1:0] accept_val;

   assign wr_unlock = wr_en && (reg_sel_e'(wr_sel) == SEL_UNLOCK);
   assign wr_presc = wr_en && (reg_sel_e'(wr_sel) == SEL_PRESC);

   gcp_unlock_win #(
      .DATA_W(DATA_W), .SIG(SIG), .WIN_INSTR(WIN_INSTR)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .wr_unlock(wr_unlock), .wr_data(wr_data),
      .instr_done(instr_done), .win_open(win_open), .rd_val(unlock_rd)
   );

   gcp_field_reg #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .RESET_SEL(RESET_SEL)
   ) u_field (
      .clk(clk), .rst_n(rst_n), .wr_presc(wr_presc), .win_open(win_open),
      .wr_data(wr_data), .field_q(presc_sel), .accept(accept),
      .accept_val(accept_val)
   );

   gcp_divider #(
      .SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .RESET_SEL(RESET_SEL)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .new_valid(accept), .new_log(accept_val),
      .tick(sys_tick)
   );

   assign irq_hold = win_open;
endmodule

// File: rtl/gcp_checker.sv
module gcp_checker #(
   parameter int DATA_W = 8,
   parameter int SEL_W = 4,
   parameter int MAX_LOG = 8,
   parameter logic [DATA_W-1:0] SIG = 8'hD8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              instr_done,
   input logic [DATA_W-1:0] unlock_rd,
   input logic              irq_hold,
   input logic [SEL_W-1:0]  presc_sel,
   input logic              sys_tick
);
   localparam logic [DATA_W-1:0] CODE_LIMIT = DATA_W'(MAX_LOG);

   p_sig_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_data == SIG) |=> irq_hold);

   p_bad_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_data != SIG && !irq_hold) |=> !irq_hold);

   p_rd_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_rd[DATA_W-1:1] == '0) && (unlock_rd[0] == irq_hold));

   p_close_on_instr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_hold) |-> $past(instr_done));

   p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !irq_hold) |=> $stable(presc_sel));

   p_field_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(presc_sel) |-> $past(wr_en && wr_sel && irq_hold));

   p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data > CODE_LIMIT) |=> $stable(presc_sel));

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_data == SIG) |=> (irq_hold && $stable(presc_sel)));

   p_tick_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(sys_tick));
endmodule

bind guarded_clk_prescaler gcp_checker #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .SIG(SIG)
) u_gcp_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .instr_done(instr_done), .unlock_rd(unlock_rd),
   .irq_hold(irq_hold), .presc_sel(presc_sel), .sys_tick(sys_tick)
);

// File: tb/guarded_clk_prescaler_test.sv
module guarded_clk_prescaler_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic instr_done = 1'b0;
   logic [7:0] unlock_rd;
   logic irq_hold;
   logic [3:0] presc_sel;
   logic sys_tick;

   guarded_clk_prescaler uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .instr_done(instr_done), .unlock_rd(unlock_rd),
      .irq_hold(irq_hold), .presc_sel(presc_sel), .sys_tick(sys_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] rd;
      logic       hold;
      logic [3:0] sel;
      string      req;
   } exp_t;
   exp_t exp_q[$];

   int  m_win = 0;
   int  m_sel = 3;
   int  m_log = 3;
   bit  m_pend = 1'b0;
   int  m_pend_log = 0;
   int  cyc = 0;
   int  last_tick = -1;

   // monitor: pops register expectations and judges strobe intervals
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (unlock_rd !== e.rd || irq_hold !== e.hold || presc_sel !== e.sel) begin
               errors++;
               $display("FAIL %s: rd=%h hold=%b sel=%0d expected rd=%h hold=%b sel=%0d",
                        e.req, unlock_rd, irq_hold, presc_sel, e.rd, e.hold, e.sel);
            end
         end
         if (sys_tick === 1'b1) begin
            checks++;
            if (cyc - last_tick != (1 << m_log)) begin
               errors++;
               $display("FAIL R9/R7 period: got %0d expected %0d", cyc - last_tick, 1 << m_log);
            end
            last_tick = cyc;
            if (m_pend) begin
               m_log = m_pend_log;
               m_pend = 1'b0;
            end
         end
         cyc++;
      end
   end

   task automatic step(input bit we, input bit sel, input logic [7:0] d, input bit done);
      bit open_before;
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; instr_done = done;
      @(posedge clk);
      open_before = (m_win > 0);
      if (we && !sel && d == 8'hD8) m_win = 4;
      else if (done && m_win > 0) m_win--;
      if (we && sel && open_before && d <= 8'd8) begin
         m_sel = d; m_pend = 1'b1; m_pend_log = d;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic expect_state(input string req);
      exp_t e;
      e.rd = (m_win > 0) ? 8'h01 : 8'h00;
      e.hold = (m_win > 0);
      e.sel = 4'(m_sel);
      e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_state("R5 reset state");
      idle(20);
      step(1, 1, 8'd0, 0); expect_state("R6 locked write");
      step(1, 0, 8'h55, 0); expect_state("R2 wrong signature");
      idle(2);
      step(1, 0, 8'hD8, 0); expect_state("R1 R3 R4 open");
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 8'h00, 1); expect_state("R1 still open");
      end
      step(0, 0, 8'h00, 1); expect_state("R1 R4 closed");
      // R8 restart
      step(1, 0, 8'hD8, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1);
      step(1, 0, 8'hD8, 0); expect_state("R8 reopen");
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 8'h00, 1); expect_state("R8 restarted count");
      end
      step(0, 0, 8'h00, 1); expect_state("R8 closed");
      // R7 reserved codes
      step(1, 0, 8'hD8, 0);
      step(1, 1, 8'd9, 0); expect_state("R7 code 9 ignored");
      step(1, 1, 8'd15, 0); expect_state("R7 code 15 ignored");
      step(1, 1, 8'd0, 0); expect_state("R7 code 0 accepted");
      idle(30);
      step(1, 0, 8'hD8, 0);
      step(1, 1, 8'd8, 0); expect_state("R7 code 8 accepted");
      idle(600);
      // R10 write on the closing instruction
      step(1, 0, 8'hD8, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1);
      step(1, 1, 8'd2, 1); expect_state("R10 write on closing instruction");
      step(1, 1, 8'd5, 0); expect_state("R6 write after close");
      idle(600);
      // R8 signature with simultaneous instruction strobe
      step(1, 0, 8'hD8, 0);
      step(0, 0, 8'h00, 1);
      step(1, 0, 8'hD8, 1); expect_state("R8 reload despite strobe");
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 8'h00, 1); expect_state("R8 open after reload");
      end
      step(1, 1, 8'd1, 0); expect_state("R9 change to code 1");
      step(0, 0, 8'h00, 1); expect_state("R8 closed after reload");
      idle(40);
      step(1, 0, 8'hD8, 0);
      step(1, 1, 8'd6, 0); expect_state("R9 change to code 6");
      idle(200);
      checks++;
      if (cyc - last_tick > 64) begin
         errors++;
         $display("FAIL R7 strobe missing: gap %0d expected at most 64", cyc - last_tick);
      end
      idle(2);
      summary();
   end
endmodule